// File: doc/BRIEF.md
# Two-Stage Register-Machine Core

A small processor that overlaps two stages on every clock. The front stage takes the instruction at the program counter, reads the source registers it names, and turns it into a decoded template. The template holds an operation, a destination index and two 32-bit operand values. The template is written into one inter-stage register that carries a valid bit. The back stage executes whatever valid template sits in that register. It writes the register file, writes data memory, or steers the program counter. The core has four operations: add, load, store and branch-when-zero.

Instruction memory and data memory are outside the core. Both answer reads combinationally. Data memory takes a write at the clock edge that ends the cycle in which `dmem_wen` is high. Neither memory port is a stream, so there is no valid/ready handshake and no back-pressure: both memories must accept a request in every cycle.

The core does not forward results between stages. When the instruction being fetched reads a register that the waiting template is about to write, the front stage holds the program counter and sends a bubble instead. A taken branch is resolved in the back stage. It overrides the front stage and discards the instruction fetched in the same cycle.

Top module: `duo_stage_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `imem_addr` is 0 and `dmem_wen` is low. No template is valid until the first edge after release.
- R2: An instruction word is 17 bits. Bits [16:15] are the operation code, [14:10] field A, [9:5] field B and [4:0] field C. Code 00 is add: register A receives reg[B] + reg[C], modulo 2^32.
- R3: Code 01 is load: register A receives the data-memory word at address reg[B]. Field C is zero.
- R4: Code 11 is store: reg[A] is written to data-memory address reg[B], with `dmem_wen` high for exactly that one execute cycle. A load that executes in the next cycle returns the stored value.
- R5: Code 10 is branch-when-zero with condition register A and target register B. If reg[A] is nonzero, the program counter simply advances by one.
- R6: If reg[A] is zero, the cycle after execute holds that branch fetches from address reg[B]. The instruction fetched while the branch executed never takes effect.
- R7: The fetched instruction may read a register that is the destination of a valid add or load waiting in the inter-stage register. The sources are A and B for branch and store, B and C for add, and B for load. In that case `imem_addr` repeats in the next cycle, and the next execute cycle does nothing.
- R8: With no branch taken and no stall, `imem_addr` rises by one every cycle, and one instruction enters execute per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Program counter, used as the instruction address |
| imem_data | input | 17 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data-memory address for the load or store in execute |
| dmem_rdata | input | 32 | Data-memory word at `dmem_addr`, same cycle |
| dmem_wen | output | 1 | Store strobe; the write lands at the closing edge |
| dmem_wdata | output | 32 | Store data |

## Verification
The address an instruction is fetched from appears on `imem_addr` in cycle k. Its store shows on `dmem_wen`, `dmem_addr` and `dmem_wdata` in cycle k+1, after one register. A dependent instruction's fetch address repeats in cycle k+1, and after a taken branch executes in cycle k, the target appears in cycle k+1. The bench steps through a reference program one cycle at a time. At the middle of each cycle it compares the fetch address and the store strobe, address and data against a table built by hand from these latencies. It then reads the memory image after the run to confirm that the loaded, added and killed values landed where R2 to R6 require.

// File: rtl/core_pkg.sv
package core_pkg;
  parameter int XLEN = 32;
  parameter int REGS = 32;
  localparam int RIDX   = $clog2(REGS);
  localparam int OPW    = 2;
  localparam int IWIDTH = OPW + 3 * RIDX;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 2'b00,
    OP_LD  = 2'b01,
    OP_BZ  = 2'b10,
    OP_ST  = 2'b11
  } op_e;

  // Decoded template: a/b carry operand values, never register names.
  // add: a+b, bz: a=condition, b=target, ld: b=address, st: a=data, b=address
  typedef struct packed {
    logic            vld;
    op_e             op;
    logic [RIDX-1:0] dst;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
  } tmpl_t;
endpackage

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] rd_idx [NRD],
  output logic [XLEN-1:0] rd_val [NRD],
  input  logic            we,
  input  logic [RIDX-1:0] widx,
  input  logic [XLEN-1:0] wval
);
  logic [XLEN-1:0] regs [REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[widx] <= wval;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_val[g] = regs[rd_idx[g]];
  end
endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [IWIDTH-1:0] instr,
  input  logic [XLEN-1:0]   rd_val [2],
  output logic [RIDX-1:0]   rd_idx [2],
  input  tmpl_t             held,
  output tmpl_t             tmpl,
  output logic              stall
);
  op_e             op;
  logic [RIDX-1:0] fa, fb, fc;
  logic            use0;
  logic            held_writes;

  assign op = op_e'(instr[IWIDTH-1 -: OPW]);
  assign fa = instr[IWIDTH-OPW-1 -: RIDX];
  assign fb = instr[IWIDTH-OPW-RIDX-1 -: RIDX];
  assign fc = instr[RIDX-1:0];

  // port 0 feeds operand a, port 1 feeds operand b
  always_comb begin
    if (op == OP_ADD) begin
      rd_idx[0] = fb;
      rd_idx[1] = fc;
    end else begin
      rd_idx[0] = fa;
      rd_idx[1] = fb;
    end
  end

  assign use0 = (op != OP_LD);

  always_comb begin
    tmpl     = '0;
    tmpl.vld = 1'b1;
    tmpl.op  = op;
    tmpl.dst = fa;
    tmpl.a   = rd_val[0];
    tmpl.b   = rd_val[1];
  end

  assign held_writes = held.vld && (held.op == OP_ADD || held.op == OP_LD);
  assign stall = held_writes &&
                 ((use0 && rd_idx[0] == held.dst) || rd_idx[1] == held.dst);
endmodule

// File: rtl/core_execute.sv
module core_execute
  import core_pkg::*;
(
  input  tmpl_t           cur,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  output logic            rf_we,
  output logic [RIDX-1:0] rf_widx,
  output logic [XLEN-1:0] rf_wval,
  output logic            taken,
  output logic [XLEN-1:0] target
);
  assign mem_addr  = cur.b;
  assign mem_wdata = cur.a;
  assign mem_we    = cur.vld && cur.op == OP_ST;

  assign rf_we   = cur.vld && (cur.op == OP_ADD || cur.op == OP_LD);
  assign rf_widx = cur.dst;
  assign rf_wval = (cur.op == OP_ADD) ? cur.a + cur.b : mem_rdata;

  assign taken  = cur.vld && cur.op == OP_BZ && cur.a == '0;
  assign target = cur.b;
endmodule

// File: rtl/duo_stage_core.sv
module duo_stage_core
  import core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [IWIDTH-1:0] imem_data,
  output logic [XLEN-1:0]   dmem_addr,
  input  logic [XLEN-1:0]   dmem_rdata,
  output logic              dmem_wen,
  output logic [XLEN-1:0]   dmem_wdata
);
  logic [XLEN-1:0] pc_q;
  tmpl_t           stage_q;
  tmpl_t           dec_tmpl;
  logic            hazard_stall;
  logic [RIDX-1:0] rd_idx [2];
  logic [XLEN-1:0] rd_val [2];
  logic            wb_we;
  logic [RIDX-1:0] wb_idx;
  logic [XLEN-1:0] wb_val;
  logic            ex_taken;
  logic [XLEN-1:0] ex_target;

  assign imem_addr = pc_q;

  core_regfile #(.NRD(2)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (rd_idx),
    .rd_val (rd_val),
    .we     (wb_we),
    .widx   (wb_idx),
    .wval   (wb_val)
  );

  core_decode u_dec (
    .instr  (imem_data),
    .rd_val (rd_val),
    .rd_idx (rd_idx),
    .held   (stage_q),
    .tmpl   (dec_tmpl),
    .stall  (hazard_stall)
  );

  core_execute u_ex (
    .cur       (stage_q),
    .mem_rdata (dmem_rdata),
    .mem_addr  (dmem_addr),
    .mem_we    (dmem_wen),
    .mem_wdata (dmem_wdata),
    .rf_we     (wb_we),
    .rf_widx   (wb_idx),
    .rf_wval   (wb_val),
    .taken     (ex_taken),
    .target    (ex_target)
  );

  // taken branch outranks a stall; both put a bubble into the stage register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      stage_q <= '0;
    end else if (ex_taken) begin
      pc_q    <= ex_target;
      stage_q <= '0;
    end else if (hazard_stall) begin
      stage_q <= '0;
    end else begin
      pc_q    <= pc_q + XLEN'(1);
      stage_q <= dec_tmpl;
    end
  end
endmodule

// File: rtl/core_chk.sv
module core_chk
  import core_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic            dmem_wen,
  input logic            stall,
  input logic            br_taken,
  input logic [XLEN-1:0] br_target
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (imem_addr == '0 && !dmem_wen));

  // R8
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(stall) && !$past(br_taken)) |->
      imem_addr == $past(imem_addr) + XLEN'(1));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(stall) && !$past(br_taken)) |->
      imem_addr == $past(imem_addr));

  // R7
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !br_taken) |=> !dmem_wen);

  // R6
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(br_taken)) |-> imem_addr == $past(br_target));

  // R6
  kill_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> !dmem_wen);
endmodule

bind duo_stage_core core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_wen  (dmem_wen),
  .stall     (hazard_stall),
  .br_taken  (ex_taken),
  .br_target (ex_target)
);

// File: tb/tb_duo_stage_core.sv
`timescale 1ns/1ps
module tb_duo_stage_core;
  localparam int IW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   imem_addr;
  logic [IW-1:0] imem_data;
  logic [31:0]   dmem_addr;
  logic [31:0]   dmem_rdata;
  logic          dmem_wen;
  logic [31:0]   dmem_wdata;

  logic [IW-1:0] prog [32];
  logic [31:0]   dmem [64];

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  assign imem_data  = prog[imem_addr[4:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (dmem_wen) dmem[dmem_addr[5:0]] <= dmem_wdata;
  end

  duo_stage_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_rdata (dmem_rdata),
    .dmem_wen   (dmem_wen),
    .dmem_wdata (dmem_wdata)
  );

  // encodings from R2..R5
  function automatic logic [IW-1:0] i_add(int d, int s1, int s2);
    return {2'b00, 5'(d), 5'(s1), 5'(s2)};
  endfunction
  function automatic logic [IW-1:0] i_ld(int d, int a);
    return {2'b01, 5'(d), 5'(a), 5'd0};
  endfunction
  function automatic logic [IW-1:0] i_bz(int c, int t);
    return {2'b10, 5'(c), 5'(t), 5'd0};
  endfunction
  function automatic logic [IW-1:0] i_st(int v, int a);
    return {2'b11, 5'(v), 5'(a), 5'd0};
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // per cycle: {fetch addr, store strobe, store addr, store data}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {8'd0,  1'b0, 8'd0, 8'd0},   // C0 reset state
    {8'd1,  1'b0, 8'd0, 8'd0},   // C1 load R2,R1 waits on R1
    {8'd1,  1'b0, 8'd0, 8'd0},   // C2 repeat
    {8'd2,  1'b0, 8'd0, 8'd0},   // C3 add waits on R2
    {8'd2,  1'b0, 8'd0, 8'd0},   // C4
    {8'd3,  1'b0, 8'd0, 8'd0},   // C5 store waits on R3
    {8'd3,  1'b0, 8'd0, 8'd0},   // C6
    {8'd4,  1'b1, 8'd1, 8'd20},  // C7 store R3(=20) to [R1=1]
    {8'd5,  1'b0, 8'd0, 8'd0},   // C8
    {8'd6,  1'b0, 8'd0, 8'd0},   // C9 untaken bz executes next
    {8'd7,  1'b0, 8'd0, 8'd0},   // C10 taken bz, pc7 fetched
    {8'd10, 1'b0, 8'd0, 8'd0},   // C11 redirected, killed store silent
    {8'd11, 1'b1, 8'd20, 8'd20}  // C12 store R4(=20) to [R3=20]
  };

  initial begin
    for (int i = 0; i < 32; i++) prog[i] = '0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    dmem[0] = 32'd1;
    dmem[1] = 32'd10;
    prog[0]  = i_ld(1, 0);      // R1 = 1
    prog[1]  = i_ld(2, 1);      // R2 = 10
    prog[2]  = i_add(3, 2, 2);  // R3 = 20
    prog[3]  = i_st(3, 1);      // mem[1] = 20
    prog[4]  = i_ld(4, 1);      // R4 = 20
    prog[5]  = i_bz(1, 3);      // not taken
    prog[6]  = i_bz(0, 2);      // taken to 10
    prog[7]  = i_st(4, 0);      // must be killed
    prog[10] = i_st(4, 3);      // mem[20] = 20

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check(imem_addr == 32'd0, "R1 pc in reset", imem_addr, 32'd0);
    check(dmem_wen == 1'b0, "R1 wen in reset", {31'd0, dmem_wen}, 32'd0);
    rst_n = 1'b1;
    #0.5;

    for (int k = 0; k < NV; k++) begin
      if (k > 0) begin
        @(negedge clk);
        #0.5;
      end
      // R5 R6 R7 R8 fetch order
      check(imem_addr == {24'd0, VEC[k][24:17]},
            $sformatf("C%0d fetch addr (R1 R5 R6 R7 R8)", k),
            imem_addr, {24'd0, VEC[k][24:17]});
      // R4 R6 R7 store strobe
      check(dmem_wen == VEC[k][16],
            $sformatf("C%0d store strobe (R4 R6 R7)", k),
            {31'd0, dmem_wen}, {31'd0, VEC[k][16]});
      if (VEC[k][16]) begin
        // R2 R3 R4 operand values
        check(dmem_addr == {24'd0, VEC[k][15:8]},
              $sformatf("C%0d store addr (R2 R3 R4)", k),
              dmem_addr, {24'd0, VEC[k][15:8]});
        check(dmem_wdata == {24'd0, VEC[k][7:0]},
              $sformatf("C%0d store data (R2 R3 R4)", k),
              dmem_wdata, {24'd0, VEC[k][7:0]});
      end
    end

    @(negedge clk);
    // R6: killed store left word 0 alone
    check(dmem[0] == 32'd1, "R6 killed store", dmem[0], 32'd1);
    // R4: store landed
    check(dmem[1] == 32'd20, "R4 stored word", dmem[1], 32'd20);
    // R3 R4: load after store saw new value
    check(dmem[20] == 32'd20, "R3 load after store", dmem[20], 32'd20);

    // R1: reset during a run returns to address 0 with no store
    rst_n = 1'b0;
    #0.5;
    check(imem_addr == 32'd0, "R1 pc after mid-run reset", imem_addr, 32'd0);
    check(dmem_wen == 1'b0, "R1 wen after mid-run reset", {31'd0, dmem_wen}, 32'd0);
    @(negedge clk);
    check(imem_addr == 32'd0, "R1 pc held in reset", imem_addr, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule